// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked system port and a 16-bit asynchronous static RAM whose two bytes can be enabled one at a time. A requester offers one access at a time with a valid/ready handshake. The access carries an address, write data, a per-byte lane mask and a direction flag. The sequencer then drives the memory's control pins for as many clock cycles as the memory's analog timing needs. Read data comes back on a response bus that is qualified by a single-cycle strobe.

Every access starts with one cycle in which only the address is driven, so the address is settled before the pair of chip selects becomes active. A read keeps chip select, output enable and the chosen byte lanes active for the whole access time, and the read data is sampled in the last of those cycles. A write lowers the write strobe together with the chip selects. It then ends the write by raising the write strobe while the address, data, lanes and chip selects stay unchanged for one more cycle. After a read, a turnaround gap lets the memory release the data bus before the controller can drive it again.

The clock period in picoseconds and a speed-grade flag are parameters. Each nanosecond limit is rounded up to whole clock cycles when the design elaborates.

Top module: `sram_timing_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, req_ready is 1, sram_ce1_n is 1, sram_ce2 is 0, sram_oe_n is 1, sram_we_n is 1, every sram_lane_n bit is 1, sram_dq_oe is 0 and rsp_valid is 0.
- R2: The address of an accepted request appears on sram_addr at least one full cycle before the chip selects go active (sram_ce1_n low together with sram_ce2 high). It does not change while they are active.
- R3: A read holds the chip selects, sram_oe_n low and the chosen lanes for exactly RD = max(ceil(tRC/T), ceil(tACE/T)) cycles. T is the clock period; tRC and tACE are 55 ns for the fast grade and 70 ns for the slow grade. The data is sampled at the edge that ends the last of these cycles.
- R4: rsp_valid is high for exactly one cycle, the cycle after the last enabled read cycle. rsp_rdata then carries the sampled word, with any lane left out of the mask forced to zero. Mask bit 0 selects bits 7:0 and drives sram_lane_n[0]; mask bit 1 selects bits 15:8 and drives sram_lane_n[1]. A mask bit of 1 enables its lane.
- R5: A write holds sram_we_n low together with the chip selects and the masked lanes for exactly WR = max(ceil(tSCE/T), ceil(tWC/T) − 1) cycles. tSCE is 45 ns for the fast grade and 55 ns for the slow grade; tWC is 55 ns or 70 ns. Output enable stays high for the whole write, and only the masked lanes of the memory word are changed.
- R6: A write ends when sram_we_n rises. In that cycle the chip selects are still active, and the address, lanes and write data have not changed.
- R7: sram_dq_oe is high only during the write-strobe cycles of a write and its final hold cycle. It is never high while output enable is low.
- R8: req_ready goes low in the cycle after a request is accepted. It stays low for 1 + RD + TA cycles after a read, where TA = max(3, ceil(25 ns/T)). It stays low for WR + 2 cycles after a write.
- R9: req_valid is ignored while req_ready is low. A request offered during a busy period neither starts an access nor changes the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_lanes | input | DATA_W/8 | Byte lane mask, 1 = lane used |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, unused lanes zero |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce1_n | output | 1 | Chip select, active low |
| sram_ce2 | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lane_n | output | DATA_W/8 | Byte lane enables, active low |
| sram_dq_out | output | DATA_W | Data driven to the memory |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions assume that reset is applied once at the start, and that the requester drops req_valid only after a handshake completes or while the controller is busy. They do not assume that the memory returns sensible data. The bench keeps to this by offering each request at a falling edge and holding it until req_ready is seen high. It clears the request right after acceptance, and it injects extra requests only inside busy windows. The behavioural memory model in the bench drives valid data only after the access time has fully passed on enabled lanes, and otherwise drives a filler pattern, so a sample taken too early shows up as a data mismatch.

// File: rtl/sram_timing_pkg.sv
package sram_timing_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACT,
      PH_HOLD,
      PH_TURN
   } phase_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // limits in picoseconds, per speed grade
   function automatic int unsigned lim_read_cycle(input bit fast);
      return fast ? 55000 : 70000;
   endfunction

   function automatic int unsigned lim_sel_to_data(input bit fast);
      return fast ? 55000 : 70000;
   endfunction

   function automatic int unsigned lim_sel_to_wend(input bit fast);
      return fast ? 45000 : 55000;
   endfunction

   function automatic int unsigned lim_write_cycle(input bit fast);
      return fast ? 55000 : 70000;
   endfunction

   function automatic int unsigned lim_bus_release(input bit fast);
      return fast ? 25000 : 25000;
   endfunction

endpackage

// File: rtl/sram_cycle_counter.sv
module sram_cycle_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign expired = (remain == '0);

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [LANES-1:0]  lane_sel,
   input  logic [DATA_W-1:0] bus_in,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_valid <= 1'b0;
      else        word_valid <= sample;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_out[g*8 +: 8] <= 8'h00;
         end else if (sample) begin
            word_out[g*8 +: 8] <= lane_sel[g] ? bus_in[g*8 +: 8] : 8'h00;
         end
      end
   end

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
   import sram_timing_pkg::*;
#(
   parameter int unsigned ADDR_W        = 18,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter bit          FAST_GRADE    = 1'b1,
   parameter int unsigned MIN_TURN      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_lanes,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     sram_addr,
   output logic                  sram_ce1_n,
   output logic                  sram_ce2,
   output logic                  sram_oe_n,
   output logic                  sram_we_n,
   output logic [DATA_W/8-1:0]   sram_lane_n,
   output logic [DATA_W-1:0]     sram_dq_out,
   output logic                  sram_dq_oe,
   input  logic [DATA_W-1:0]     sram_dq_in
);

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned RD_CYC = umax(ceil_div(lim_read_cycle(FAST_GRADE), CLK_PERIOD_PS),
                                         ceil_div(lim_sel_to_data(FAST_GRADE), CLK_PERIOD_PS));
   localparam int unsigned WR_CYC = umax(umax(ceil_div(lim_sel_to_wend(FAST_GRADE), CLK_PERIOD_PS),
                                              ceil_div(lim_write_cycle(FAST_GRADE), CLK_PERIOD_PS) - 1), 1);
   localparam int unsigned TA_CYC = umax(MIN_TURN, ceil_div(lim_bus_release(FAST_GRADE), CLK_PERIOD_PS));
   localparam int unsigned MAX_CYC = umax(RD_CYC, umax(WR_CYC, TA_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

   // elaboration-time parameter checks
   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (ADDR_W == 0) begin : g_bad_addr_w
      $error("ADDR_W must be non-zero");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_clk
      $error("CLK_PERIOD_PS must be non-zero");
   end
   if (MIN_TURN == 0) begin : g_bad_turn
      $error("MIN_TURN must be at least one cycle");
   end

   phase_e              phase, phase_nxt;
   logic                op_wr;
   logic [ADDR_W-1:0]   op_addr;
   logic [DATA_W-1:0]   op_wdata;
   logic [LANES-1:0]    op_lanes;
   logic                cnt_load;
   logic [CNT_W-1:0]    cnt_val;
   logic                cnt_done;
   logic                rd_sample;
   logic                en_nxt;

   assign req_ready = (phase == PH_IDLE);

   always_comb begin
      phase_nxt = phase;
      cnt_load  = 1'b0;
      cnt_val   = '0;
      rd_sample = 1'b0;
      unique case (phase)
         PH_IDLE: if (req_valid) phase_nxt = PH_ADDR;
         PH_ADDR: begin
            phase_nxt = PH_ACT;
            cnt_load  = 1'b1;
            cnt_val   = op_wr ? WR_LD : RD_LD;
         end
         PH_ACT: if (cnt_done) begin
            if (op_wr) begin
               phase_nxt = PH_HOLD;
            end else begin
               phase_nxt = PH_TURN;
               cnt_load  = 1'b1;
               cnt_val   = TA_LD;
               rd_sample = 1'b1;
            end
         end
         PH_HOLD: phase_nxt = PH_IDLE;
         PH_TURN: if (cnt_done) phase_nxt = PH_IDLE;
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         op_wr    <= 1'b0;
         op_addr  <= '0;
         op_wdata <= '0;
         op_lanes <= '0;
      end else begin
         phase <= phase_nxt;
         if (req_ready && req_valid) begin
            op_wr    <= req_write;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            op_lanes <= req_lanes;
         end
      end
   end

   // memory pins come straight from flops loaded with the next phase
   assign en_nxt = (phase_nxt == PH_ACT) || (phase_nxt == PH_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sram_ce1_n  <= 1'b1;
         sram_ce2    <= 1'b0;
         sram_oe_n   <= 1'b1;
         sram_we_n   <= 1'b1;
         sram_lane_n <= '1;
         sram_dq_oe  <= 1'b0;
      end else begin
         sram_ce1_n  <= !en_nxt;
         sram_ce2    <= en_nxt;
         sram_oe_n   <= !((phase_nxt == PH_ACT) && !op_wr);
         sram_we_n   <= !((phase_nxt == PH_ACT) && op_wr);
         sram_lane_n <= en_nxt ? ~op_lanes : '1;
         sram_dq_oe  <= en_nxt && op_wr;
      end
   end

   assign sram_addr   = op_addr;
   assign sram_dq_out = op_wdata;

   sram_cycle_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .expired  (cnt_done)
   );

   sram_read_capture #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample     (rd_sample),
      .lane_sel   (op_lanes),
      .bus_in     (sram_dq_in),
      .word_valid (rsp_valid),
      .word_out   (rsp_rdata)
   );

endmodule

// File: rtl/sram_timing_ctrl_chk.sv
module sram_timing_ctrl_chk #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce1_n,
   input logic              sram_oe_n,
   input logic              sram_we_n,
   input logic [LANES-1:0]  sram_lane_n,
   input logic [DATA_W-1:0] sram_dq_out,
   input logic              sram_dq_oe
);

   // R2: address is held while the chip is selected
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));

   // R2: address already settled in the cycle before selection
   a_r2_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_ce1_n) |-> $stable(sram_addr));

   // R3: output enable only inside a selected cycle
   a_r3_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !sram_ce1_n);

   // R4: response strobe lasts one cycle
   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R5: never read and write enable together
   a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_oe_n && !sram_we_n));

   // R6: write ends on the strobe with everything else held
   a_r6_strobe_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (!sram_ce1_n && sram_dq_oe && $stable(sram_lane_n)
                            && $stable(sram_dq_out) && $stable(sram_addr)));

   // R7: bus driven only for a selected write
   a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (!sram_ce1_n && sram_oe_n));

   // R8: no handshake while the memory is selected
   a_r8_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce1_n |-> !req_ready);

endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LANES  (LANES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .sram_addr   (sram_addr),
   .sram_ce1_n  (sram_ce1_n),
   .sram_oe_n   (sram_oe_n),
   .sram_we_n   (sram_we_n),
   .sram_lane_n (sram_lane_n),
   .sram_dq_out (sram_dq_out),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_timing_ctrl_tb.sv
`timescale 1ns/1ps
module sram_timing_ctrl_tb;

   localparam int AW     = 8;
   localparam int DW     = 16;
   localparam int CLK_PS = 4000;

   function automatic int up_div(input int n, input int d);
      return (n + d - 1) / d;
   endfunction
   function automatic int bigger(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int EXP_RD = bigger(up_div(55000, CLK_PS), up_div(55000, CLK_PS));
   localparam int EXP_WR = bigger(up_div(45000, CLK_PS), up_div(55000, CLK_PS) - 1);
   localparam int EXP_TA = bigger(3, up_div(25000, CLK_PS));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_lanes = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic          sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [1:0]    sram_lane_n;
   logic [DW-1:0] sram_dq_out;
   logic [DW-1:0] sram_dq_in;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sram_timing_ctrl #(
      .ADDR_W        (AW),
      .DATA_W        (DW),
      .CLK_PERIOD_PS (CLK_PS),
      .FAST_GRADE    (1'b1),
      .MIN_TURN      (3)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_lanes (req_lanes),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .sram_addr (sram_addr), .sram_ce1_n (sram_ce1_n), .sram_ce2 (sram_ce2),
      .sram_oe_n (sram_oe_n), .sram_we_n (sram_we_n), .sram_lane_n (sram_lane_n),
      .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe), .sram_dq_in (sram_dq_in)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory ----------------
   logic [DW-1:0] mem [256];
   logic [DW-1:0] sb  [256];
   int  sel_cnt = 0;
   int  we_cnt  = 0;
   int  rd_len  = 0;
   logic prev_sel = 1'b0;
   logic prev_we  = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   logic sel;

   assign sel = !sram_ce1_n && sram_ce2;

   always_comb begin
      for (int l = 0; l < 2; l++) begin
         if (sel && !sram_oe_n && !sram_lane_n[l] && sel_cnt >= EXP_RD)
            sram_dq_in[l*8 +: 8] = mem[sram_addr][l*8 +: 8];
         else
            sram_dq_in[l*8 +: 8] = 8'hEE;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (sel && !prev_sel) // R2 address visible a cycle ahead
            chk(sram_addr == prev_addr, "R2 addr before select", sram_addr, prev_addr);
         if (sel) sel_cnt = sel_cnt + 1; else sel_cnt = 0;
         if (sel && !sram_oe_n) rd_len = rd_len + 1;
         if (sel && !sram_we_n) we_cnt = we_cnt + 1;
         if (prev_sel && !sel && rd_len != 0) begin
            chk(rd_len == EXP_RD, "R3 read enable length", rd_len, EXP_RD);
            rd_len = 0;
         end
         if (!prev_we && sram_we_n) begin
            chk(sel, "R6 select held at strobe rise", sel, 1);
            chk(sram_addr == prev_addr, "R6 addr held at strobe rise", sram_addr, prev_addr);
            chk(we_cnt == EXP_WR, "R5 write strobe length", we_cnt, EXP_WR);
            chk(sram_dq_oe, "R7 bus driven at write end", sram_dq_oe, 1);
            for (int l = 0; l < 2; l++)
               if (!sram_lane_n[l]) mem[sram_addr][l*8 +: 8] = sram_dq_out[l*8 +: 8];
            we_cnt = 0;
         end
         prev_sel  = sel;
         prev_we   = sram_we_n;
         prev_addr = sram_addr;
      end
   end

   function automatic logic [DW-1:0] masked(input logic [DW-1:0] w, input logic [1:0] ln);
      return {ln[1] ? w[15:8] : 8'h00, ln[0] ? w[7:0] : 8'h00};
   endfunction

   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] ln, input bit inject);
      int busy = 0;
      int nrsp = 0;
      logic [DW-1:0] got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) begin
         busy++;
         if (rsp_valid) begin nrsp++; got = rsp_rdata; end
         if (inject && busy == 3) begin // R9 offer a request while busy
            req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd10;
            req_wdata = 16'hBAD0; req_lanes = 2'b11;
         end
         if (inject && busy == 6) req_valid = 1'b0;
         @(negedge clk);
      end
      if (wr) begin
         chk(busy == EXP_WR + 2, "R8 write busy length", busy, EXP_WR + 2);
         chk(nrsp == 0, "R4 no strobe on write", nrsp, 0);
         for (int l = 0; l < 2; l++)
            if (ln[l]) sb[a][l*8 +: 8] = d[l*8 +: 8];
      end else begin
         chk(busy == 1 + EXP_RD + EXP_TA, "R8 read busy length", busy, 1 + EXP_RD + EXP_TA);
         chk(nrsp == 1, "R4 strobe count", nrsp, 1);
         chk(got == masked(sb[a], ln), "R4 read data", got, masked(sb[a], ln));
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin mem[i] = '0; sb[i] = '0; end
      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1 && sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n,
          "R1 controls in reset", {req_ready, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n}, 5'b11011);
      chk(sram_lane_n == 2'b11 && !sram_dq_oe && !rsp_valid, "R1 lanes and bus in reset",
          {sram_lane_n, sram_dq_oe, rsp_valid}, 4'b1100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && sram_ce1_n && !sram_dq_oe, "R1 idle after release",
          {req_ready, sram_ce1_n, sram_dq_oe}, 3'b110);

      // directed lane and ordering cases
      do_req(1'b1, 8'd5, 16'h1234, 2'b11, 1'b0);
      do_req(1'b0, 8'd5, 16'h0000, 2'b11, 1'b0);
      do_req(1'b1, 8'd5, 16'hABCD, 2'b01, 1'b0);   // R5 low lane only
      do_req(1'b0, 8'd5, 16'h0000, 2'b10, 1'b0);   // R4 low lane forced zero
      do_req(1'b1, 8'd5, 16'h5566, 2'b10, 1'b0);
      do_req(1'b0, 8'd5, 16'h0000, 2'b01, 1'b0);
      do_req(1'b0, 8'd5, 16'h0000, 2'b11, 1'b0);
      do_req(1'b1, 8'd9, 16'h7777, 2'b11, 1'b1);   // R9 injected request
      do_req(1'b0, 8'd10, 16'h0000, 2'b11, 1'b0);  // R9 address 10 untouched
      do_req(1'b0, 8'd9, 16'h0000, 2'b11, 1'b1);

      // random mix
      for (int k = 0; k < 80; k++) begin
         logic [1:0] ln;
         ln = 2'($urandom_range(1, 3));
         do_req(1'($urandom_range(0, 1)), 8'($urandom_range(0, 15)),
                16'($urandom), ln, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog expired, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule